// File: doc/BRIEF.md
# Stepper Bridge Enable and Wake Sequencer

This block decides, cycle by cycle, whether the two motor bridges may drive current and whether the step translator may move. It looks at five conditions: an output-disable input, a hold-at-home input, a sleep input, a power-on-busy indication, and two fault flags for over-temperature and undervoltage. From these it produces three signals. The first is a bridge enable for the current chopper. The second is a home request that keeps the translator parked at its home position. The third is a step-accept qualifier, which also gates incoming step pulses into a qualified step strobe.

Sleep and power-on both send the block to an off phase, where the translator is held at home. Once both have cleared, the block spends a programmable wake interval, still at home with outputs off, before it enters the run phase. The default interval is 1 ms at a 1 MHz clock. Step pulses that arrive before the run phase begins are discarded and are not held for later.

The output-disable input only cuts the bridge drive, so stepping continues while it is high. A fault also only cuts the bridge drive, and the translator position is kept until the fault clears. The fault flags are asynchronous and pass through two-flop synchronisers. All other inputs are synchronous and are registered once.

Top module: `motor_gate_seq`

## Requirements
- R1: `drv_disable` high, sampled at a clock edge, makes `bridge_en` 0 after that edge. It does not change `home_req` or `step_ok`.
- R2: `park_n` low, sampled at an edge, makes the outputs after that edge `bridge_en`=0, `home_req`=1 and `step_ok`=0. The phase is kept, so when `park_n` returns high in the run phase, stepping resumes one clock later with no wake interval.
- R3: `sleep_n` low, sampled at an edge, puts the block in the off phase after that edge, with `bridge_en`=0, `home_req`=1 and `step_ok`=0.
- R4: The first edge that samples `sleep_n`=1 and `por_busy`=0 while the block is off starts the wake phase. The wake phase lasts exactly `WAKE_CYCLES` clocks with `bridge_en`=0, `home_req`=1 and `step_ok`=0. After that the run phase begins, and `step_ok` is 1 unless parked.
- R5: A level on `ot_flag` or `uv_flag` is held for two clock edges before it forces `bridge_en` to 0. Its removal takes the same two edges before `bridge_en` may return. Faults never change `home_req` or `step_ok`.
- R6: `por_busy` high, sampled at an edge, has the same effect as sleep: off phase and home request after that edge, and a full wake interval once it drops.
- R7: `step_go` equals `step_pulse` AND `step_ok` within the same cycle. Pulses given while `step_ok` is 0 produce no `step_go`, either then or later.
- R8: In the run phase, `bridge_en` is 1 on the first clock after the disable, park and synchronised fault conditions are all gone.
- R9: While `rst` is high, every following clock shows `bridge_en`=0, `home_req`=1, `step_ok`=0 and `step_go`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| drv_disable | input | 1 | High blocks bridge drive only |
| park_n | input | 1 | Low holds translator at home and blocks drive |
| sleep_n | input | 1 | Low enters the off phase |
| por_busy | input | 1 | High while supply is coming up |
| ot_flag | input | 1 | Asynchronous over-temperature flag |
| uv_flag | input | 1 | Asynchronous undervoltage flag |
| step_pulse | input | 1 | One-clock step request from edge detection |
| bridge_en | output | 1 | Enable for the chopper and bridges |
| home_req | output | 1 | Request to force translator to home |
| step_ok | output | 1 | Translator may advance |
| step_go | output | 1 | Qualified step strobe |

## Verification
The hardest situations to reach are coincidences at the end of the wake interval. One is a step pulse in the last wake cycle. Another is a fault whose synchronised level clears exactly as the run phase begins. A third is sleep reasserted partway through a wake. Random stimulus seldom lines these up, so the bench uses a short wake interval and directed sequences that count clocks from the sleep release and place pulses and fault edges on those exact cycles. A cycle-level model of the requirements is compared with every output on every clock during a long random run that has weighted sleep, power-on and fault activity.

// File: rtl/mgs_pkg.sv
package mgs_pkg;

    typedef enum logic [1:0] {
        PH_OFF  = 2'd0,
        PH_WAKE = 2'd1,
        PH_RUN  = 2'd2
    } phase_t;

    typedef struct packed {
        logic dis;
        logic park;
    } gate_req_t;

    function automatic logic must_idle(input logic sleep_n, input logic por_busy);
        return (!sleep_n) || por_busy;
    endfunction

endpackage

// File: rtl/mgs_sync.sv
module mgs_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] chain [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            always_ff @(posedge clk) begin
                if (rst) chain[s] <= '0;
                else if (s == 0) chain[s] <= d;
                else chain[s] <= chain[(s == 0) ? 0 : s-1];
            end
        end
    endgenerate

    assign q = chain[STAGES-1];
endmodule

// File: rtl/mgs_phase_ctrl.sv
module mgs_phase_ctrl
    import mgs_pkg::*;
#(
    parameter int WAKE_CYCLES = 1000
) (
    input  logic   clk,
    input  logic   rst,
    input  logic   sleep_n,
    input  logic   por_busy,
    output phase_t phase
);
    localparam int CW = $clog2(WAKE_CYCLES + 1);
    localparam logic [CW-1:0] LAST = CW'(WAKE_CYCLES - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= PH_OFF;
            cnt   <= '0;
        end else if (must_idle(sleep_n, por_busy)) begin
            phase <= PH_OFF;
            cnt   <= '0;
        end else begin
            unique case (phase)
                PH_OFF: begin
                    phase <= PH_WAKE;
                    cnt   <= '0;
                end
                PH_WAKE: begin
                    if (cnt == LAST) phase <= PH_RUN;
                    else cnt <= cnt + 1'b1;
                end
                default: phase <= PH_RUN;
            endcase
        end
    end

    AST_WAKE_BOUND: assert property (@(posedge clk) disable iff (rst)
        phase == PH_WAKE |-> cnt < CW'(WAKE_CYCLES)); // R4
    AST_RUN_VIA_WAKE: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_RUN && $past(phase) != PH_RUN) |-> $past(phase) == PH_WAKE); // R4
    AST_IDLE_GOES_OFF: assert property (@(posedge clk) disable iff (rst)
        (!sleep_n || por_busy) |=> phase == PH_OFF); // R3
endmodule

// File: rtl/mgs_gate.sv
module mgs_gate
    import mgs_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   drv_disable,
    input  logic   park_n,
    input  logic   fault_s,
    input  phase_t phase,
    input  logic   step_pulse,
    output logic   bridge_en,
    output logic   home_req,
    output logic   step_ok,
    output logic   step_go
);
    gate_req_t req_q;

    always_ff @(posedge clk) begin
        if (rst) req_q <= '0;
        else begin
            req_q.dis  <= drv_disable;
            req_q.park <= !park_n;
        end
    end

    logic running;
    always_comb begin
        running   = (phase == PH_RUN);
        bridge_en = running && !req_q.dis && !req_q.park && !fault_s;
        home_req  = !running || req_q.park;
        step_ok   = running && !req_q.park;
        step_go   = step_ok && step_pulse;
    end

    AST_DISABLE_CUTS: assert property (@(posedge clk) disable iff (rst)
        drv_disable |=> !bridge_en); // R1
    AST_PARK_HOLDS: assert property (@(posedge clk) disable iff (rst)
        !park_n |=> (home_req && !step_ok && !bridge_en)); // R2
    AST_FAULT_CUTS: assert property (@(posedge clk) disable iff (rst)
        fault_s |-> !bridge_en); // R5
endmodule

// File: rtl/motor_gate_seq.sv
module motor_gate_seq
    import mgs_pkg::*;
#(
    parameter int WAKE_CYCLES = 1000,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic drv_disable,
    input  logic park_n,
    input  logic sleep_n,
    input  logic por_busy,
    input  logic ot_flag,
    input  logic uv_flag,
    input  logic step_pulse,
    output logic bridge_en,
    output logic home_req,
    output logic step_ok,
    output logic step_go
);
    localparam int NFLT = 2;

    logic [NFLT-1:0] flt_s;
    logic            fault_s;
    phase_t          phase;

    mgs_sync #(.WIDTH(NFLT), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .d({ot_flag, uv_flag}), .q(flt_s)
    );

    assign fault_s = |flt_s;

    mgs_phase_ctrl #(.WAKE_CYCLES(WAKE_CYCLES)) u_phase (
        .clk(clk), .rst(rst), .sleep_n(sleep_n), .por_busy(por_busy), .phase(phase)
    );

    mgs_gate u_gate (
        .clk(clk), .rst(rst), .drv_disable(drv_disable), .park_n(park_n),
        .fault_s(fault_s), .phase(phase), .step_pulse(step_pulse),
        .bridge_en(bridge_en), .home_req(home_req), .step_ok(step_ok), .step_go(step_go)
    );

    AST_SLEEP_OFF: assert property (@(posedge clk) disable iff (rst)
        !sleep_n |=> (!bridge_en && home_req && !step_ok)); // R3
    AST_POR_OFF: assert property (@(posedge clk) disable iff (rst)
        por_busy |=> (!bridge_en && home_req && !step_ok)); // R6
    AST_RESET_STATE: assert property (@(posedge clk)
        rst |=> (!bridge_en && home_req && !step_ok)); // R9
endmodule

// File: tb/tb_motor_gate_seq.sv
module tb_motor_gate_seq;
    localparam int CLK_PERIOD = 10;
    localparam int WAKE = 20;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic drv_disable = 1'b0, park_n = 1'b1, sleep_n = 1'b1, por_busy = 1'b0;
    logic ot_flag = 1'b0, uv_flag = 1'b0, step_pulse = 1'b0;
    logic bridge_en, home_req, step_ok, step_go;

    always #(CLK_PERIOD/2) clk = ~clk;

    motor_gate_seq #(.WAKE_CYCLES(WAKE), .SYNC_STAGES(2)) dut (
        .clk(clk), .rst(rst), .drv_disable(drv_disable), .park_n(park_n),
        .sleep_n(sleep_n), .por_busy(por_busy), .ot_flag(ot_flag), .uv_flag(uv_flag),
        .step_pulse(step_pulse), .bridge_en(bridge_en), .home_req(home_req),
        .step_ok(step_ok), .step_go(step_go)
    );

    int n_checks = 0;
    int n_fail = 0;
    int cycles = 0;
    bit done = 0;

    // requirement model: 0 off, 1 wake, 2 run
    int m_ph = 0, m_cnt = 0;
    bit m_dis = 0, m_park = 0, m_s1 = 0, m_s2 = 0;

    function automatic bit exp_en();   return m_ph == 2 && !m_dis && !m_park && !m_s2; endfunction
    function automatic bit exp_home(); return m_ph != 2 || m_park; endfunction
    function automatic bit exp_ok();   return m_ph == 2 && !m_park; endfunction

    task automatic check(input string tag, input logic act, input logic exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %b expected %b at cycle %0d", tag, act, exp, cycles);
        end
    endtask

    task automatic model_edge();
        if (rst) begin
            m_ph = 0; m_cnt = 0; m_dis = 0; m_park = 0; m_s1 = 0; m_s2 = 0;
        end else begin
            m_s2 = m_s1; m_s1 = ot_flag | uv_flag;
            m_dis = drv_disable; m_park = !park_n;
            if (!sleep_n || por_busy) begin m_ph = 0; m_cnt = 0; end
            else if (m_ph == 0) begin m_ph = 1; m_cnt = 0; end
            else if (m_ph == 1) begin
                if (m_cnt == WAKE-1) m_ph = 2; else m_cnt++;
            end
        end
    endtask

    task automatic tick();
        @(posedge clk);
        model_edge();
        cycles++;
        @(negedge clk);
        check("R1 R5 R8 bridge_en", bridge_en, exp_en());
        check("R2 R3 R6 home_req", home_req, exp_home());
        check("R2 R4 step_ok", step_ok, exp_ok());
    endtask

    task automatic pulse_check(input logic p);
        step_pulse = p;
        #1;
        check("R7 step_go", step_go, p & exp_ok());
    endtask

    initial begin
        #(CLK_PERIOD * 190000);
        if (!done) begin
            n_fail++;
            n_checks++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        int r;
        int wake_len;
        void'($urandom(32'h5eed_1234));
        @(negedge clk);
        // R9: reset state
        repeat (3) begin
            tick();
            check("R9 bridge_en", bridge_en, 1'b0);
            check("R9 home_req", home_req, 1'b1);
            check("R9 step_ok", step_ok, 1'b0);
            pulse_check(1'b1);
            check("R9 step_go", step_go, 1'b0);
        end
        step_pulse = 0;
        rst = 0;
        // R4: exact wake length, pulses dropped (R7)
        wake_len = 0;
        tick();
        while (!step_ok && wake_len < WAKE + 5) begin
            wake_len++;
            check("R4 home during wake", home_req, 1'b1);
            pulse_check(1'b1);
            check("R7 dropped in wake", step_go, 1'b0);
            tick();
        end
        check("R4 wake length", 1'(wake_len == WAKE), 1'b1);
        pulse_check(1'b0);
        check("R7 no queued step", step_go, 1'b0);
        check("R8 enabled in run", bridge_en, 1'b1);
        pulse_check(1'b1);
        check("R7 step accepted", step_go, 1'b1);
        pulse_check(1'b0);
        // R1: disable keeps stepping
        drv_disable = 1; tick();
        check("R1 bridge off", bridge_en, 1'b0);
        check("R1 step_ok kept", step_ok, 1'b1);
        drv_disable = 0; tick();
        check("R8 reenable", bridge_en, 1'b1);
        // R5: fault two-edge latency
        ot_flag = 1; tick();
        check("R5 first edge", bridge_en, 1'b1);
        tick();
        check("R5 second edge", bridge_en, 1'b0);
        check("R5 step_ok kept", step_ok, 1'b1);
        check("R5 home unaffected", home_req, 1'b0);
        ot_flag = 0; uv_flag = 1; tick(); tick();
        uv_flag = 0; tick();
        check("R5 still held", bridge_en, 1'b0);
        tick();
        check("R5 released", bridge_en, 1'b1);
        // R2: park keeps phase
        park_n = 0; tick();
        check("R2 parked home", home_req, 1'b1);
        park_n = 1; tick();
        check("R2 resume no wake", step_ok, 1'b1);
        // R3: sleep mid-wake restarts
        sleep_n = 0; tick();
        check("R3 sleep off", step_ok, 1'b0);
        sleep_n = 1;
        repeat (WAKE/2) tick();
        sleep_n = 0; tick();
        sleep_n = 1;
        repeat (WAKE) tick();
        check("R3 restarted wake", step_ok, 1'b0);
        // fault clearing exactly as run begins
        ot_flag = 1; tick();
        ot_flag = 0; tick();
        check("R4 enters run", step_ok, 1'b1);
        check("R5 fault tail", bridge_en, 1'b0);
        tick();
        check("R8 first clean clock", bridge_en, 1'b1);
        // R6: power-on busy
        por_busy = 1; tick();
        check("R6 por home", home_req, 1'b1);
        por_busy = 0;
        // random phase
        for (int i = 0; i < 4000; i++) begin
            r = $urandom_range(0, 999);
            sleep_n     = (r < 8) ? 1'b0 : 1'b1;
            por_busy    = (r > 995);
            drv_disable = ($urandom_range(0, 9) == 0);
            park_n      = ($urandom_range(0, 19) != 0);
            ot_flag     = ($urandom_range(0, 29) == 0);
            uv_flag     = ($urandom_range(0, 39) == 0);
            rst         = ($urandom_range(0, 1999) == 0);
            pulse_check(1'($urandom_range(0, 2) == 0));
            tick();
        end
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule